// File: doc/BRIEF.md
# Presettable Synchronous Decade Counter

This block is one decimal digit of a synchronous counter. On each rising clock edge it either loads a 4-bit value, advances by one through the BCD sequence 0 to 9 and back to 0, or holds its value. A low level on the clear input forces the count to zero at once, without waiting for the clock.

Counting needs two active-high enables. One of them, the trickle enable, also gates a combinational terminal-count flag that goes high at count 9. The flag of one digit drives the trickle enable of the next digit. A chain of digits therefore counts decimally, with every digit on the same clock. Codes 10 to 15 can only enter the counter through a load. From there they step upward to 15 and then return to 0.

Top module: `decade_counter`

## Requirements
- R1: While `clearN` is low, `q` is 0000 at once, with no clock edge needed, whatever `loadN`, `enPar`, `enTrickle` and `dIn` are doing.
- R2: When `loadN` is low at a rising edge and `clearN` is high, `q` takes `dIn`, whatever the levels of `enPar` and `enTrickle`.
- R3: When `loadN`, `enPar` and `enTrickle` are all high at a rising edge, `q` increases by one.
- R4: When `q` is 9 (1001) and the counter advances, the next value of `q` is 0000.
- R5: With `loadN` high, `q` keeps its value across a rising edge if `enPar` is low or `enTrickle` is low.
- R6: `tc` is high exactly when `enTrickle` is high and `q` is 9. It is combinational, so it follows a change of `enTrickle` with no clock edge.
- R7: A loaded code from 10 to 15 advances by one per enabled edge, and 15 is followed by 0. `tc` stays low at all of these codes.
- R8: When `tc` of one digit drives `enTrickle` of a second digit, and both share `enPar` and the clock, the pair counts 00 to 99 and then wraps to 00.
- R9: Clear has the highest priority. A low `loadN` while `clearN` is low leaves `q` at 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| clearN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| enPar | input | 1 | Count enable, active high; does not affect `tc` |
| enTrickle | input | 1 | Count enable, active high; also gates `tc` |
| dIn | input | 4 | Value to load |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal-count flag: `enTrickle` AND (`q` == 9) |

## Verification
The only internal state is the count register. A wrong next-state choice therefore shows on `q` at the first clock edge after the bad stimulus. A wrong terminal decode shows on `tc` in the same cycle, or one edge later on a chained digit. The main risk points are the 9-to-0 wrap and the 15-to-0 roll-over. The bench also checks that a load wins over the enables and that clear wins over a load. A chained pair that counts 100 edges shows a fault in wrapping or in terminal gating as a wrong tens digit.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // Strobes from the control decode to the count register
  typedef struct packed {
    logic load;   // take the parallel value
    logic step;   // advance by one
  } ctrlStrobe_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic        loadN,
  input  logic        enPar,
  input  logic        enTrickle,
  output ctrlStrobe_t strobe
);
  // Load overrides both enables; counting needs both enables
  always_comb begin
    strobe.load = ~loadN;
    strobe.step = loadN & enPar & enTrickle;
  end
endmodule

// File: rtl/decade_dp.sv
module decade_dp
  import decade_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             clearN,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] q,
  output logic             atLast
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = q;
    if (strobe.load)
      countNext = dIn;
    else if (strobe.step)
      countNext = (q == LAST_V) ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) q <= '0;
    else         q <= countNext;
  end

  assign atLast = (q == LAST_V);

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clearN |-> (q == '0)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(strobe.load)) |-> (q == $past(dIn))); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(strobe.step) && ($past(q) != LAST_V))
      |-> (q == $past(q) + 1'b1)); // R3

  AST_WRAP_LAST: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(strobe.step) && ($past(q) == LAST_V))
      |-> (q == '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && !$past(strobe.load) && !$past(strobe.step))
      |-> $stable(q)); // R5
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enPar,
  input  logic             enTrickle,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  ctrlStrobe_t strobe;
  logic        atLast;

  decade_ctrl uCtrl (
    .loadN     (loadN),
    .enPar     (enPar),
    .enTrickle (enTrickle),
    .strobe    (strobe)
  );

  decade_dp #(.WIDTH(WIDTH), .LAST(LAST)) uDp (
    .clk    (clk),
    .clearN (clearN),
    .strobe (strobe),
    .dIn    (dIn),
    .q      (q),
    .atLast (atLast)
  );

  // Trickle enable is fed forward to the terminal flag, unregistered
  assign tc = enTrickle & atLast;

  AST_TC_GATED: assert property (@(posedge clk) disable iff (!clearN)
    !enTrickle |-> !tc); // R6

  AST_TC_AT_LAST: assert property (@(posedge clk) disable iff (!clearN)
    tc |-> (q == WIDTH'(LAST))); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk)
    (!clearN && !loadN) |-> (q == '0)); // R9
endmodule

// File: tb/tb_decade_counter.sv
module tb_decade_counter;
  logic       clk = 0;
  logic       clearN, loadN, enPar, enTrickle;
  logic [3:0] dIn;
  logic [3:0] q, hiQ;
  logic       tc, hiTc;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 0;

  always #4 clk = ~clk; // 125 MHz

  decade_counter dut (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enPar(enPar),
    .enTrickle(enTrickle), .dIn(dIn), .q(q), .tc(tc)
  );

  // Tens digit for the chained test
  decade_counter hiStage (
    .clk(clk), .clearN(clearN), .loadN(1'b1), .enPar(enPar),
    .enTrickle(tc), .dIn(4'd0), .q(hiQ), .tc(hiTc)
  );

  // {loadN, enPar, enTrickle, dIn[3:0], expQ[3:0], expTc}
  localparam logic [11:0] VEC [14] = '{
    {1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0}, // R2 load with enables low
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0}, // R3 count
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1}, // R3 R6 count to 9
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b1}, // R5 parallel enable low
    {1'b1, 1'b1, 1'b0, 4'd0,  4'd9,  1'b0}, // R5 R6 trickle low
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0}, // R4 wrap 9 to 0
    {1'b0, 1'b0, 1'b1, 4'd9,  4'd9,  1'b1}, // R2 R6 load 9
    {1'b0, 1'b1, 1'b1, 4'd3,  4'd3,  1'b0}, // R2 load beats enables
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd4,  1'b0}, // R3
    {1'b0, 1'b1, 1'b1, 4'd14, 4'd14, 1'b0}, // R7 load 14
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0}, // R7
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0}, // R7 15 to 0
    {1'b0, 1'b1, 1'b1, 4'd10, 4'd10, 1'b0}, // R7 load 10
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd11, 1'b0}  // R7
  };

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish();
  end

  initial begin
    clearN = 0; loadN = 1; enPar = 0; enTrickle = 0; dIn = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset q", int'(q), 0);
    check("R1 reset tc", int'(tc), 0);
    @(negedge clk) clearN = 1;

    // Table walk
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {loadN, enPar, enTrickle, dIn} = VEC[i][11:5];
      @(posedge clk);
      #1;
      check($sformatf("R2-table row %0d q", i), int'(q), int'(VEC[i][4:1]));
      check($sformatf("R6 table row %0d tc", i), int'(tc), int'(VEC[i][0]));
    end

    // R6: tc follows trickle enable without an edge
    @(negedge clk);
    loadN = 0; enPar = 0; enTrickle = 0; dIn = 4'd9;
    @(posedge clk); #1;
    check("R6 tc low, trickle off", int'(tc), 0);
    @(negedge clk);
    loadN = 1; enTrickle = 1;
    #1 check("R6 tc rises combinationally", int'(tc), 1);
    enTrickle = 0;
    #1 check("R6 tc falls combinationally", int'(tc), 0);

    // R1: asynchronous clear between edges
    @(negedge clk);
    loadN = 0; dIn = 4'd5;
    @(posedge clk); #1;
    check("R2 load 5", int'(q), 5);
    @(negedge clk);
    loadN = 1;
    #1 clearN = 0;
    #1 check("R1 clear without edge", int'(q), 0);

    // R9: clear beats load
    loadN = 0; dIn = 4'd6; enPar = 1; enTrickle = 1;
    @(posedge clk); #1;
    check("R9 clear over load", int'(q), 0);

    // R8: chained pair counts 00..99 and wraps
    @(negedge clk);
    loadN = 1; enPar = 1; enTrickle = 1;
    clearN = 1;
    for (int i = 1; i <= 105; i++) begin
      @(posedge clk); #1;
      check($sformatf("R8 cascade step %0d", i),
            int'(hiQ) * 10 + int'(q), i % 100);
    end

    finish();
  end
endmodule